// File: doc/BRIEF.md
# Successive-Approximation ADC Host Control Logic

This block holds the digital control side of a 12-bit successive-approximation converter, modelled one clock at a time. A host drives an enable (`chip_en`), an active-low select (`chip_sel_n`), a read/convert line (`rd_convn`), a byte selector (`byte_sel`) and a bus-width strap (`wide_mode`). A conversion begins on the clock where the combined convert condition first becomes true. The convert condition is enable high, select low and read/convert low. Any of the three lines may be the last to arrive, or all three may change together. The block then runs one binary-search decision per clock against the `cmp_in` comparator bit. It shows the trial word on `dac_code` so that the analog side can compare against it.

When the search is over, the host reads the result through registered data lines. Each line has its own output enable, which stands for a tri-state buffer. A 12-bit bus takes every line at once. An 8-bit bus takes the result as two left-justified bytes chosen by `byte_sel`. When the byte selection changes, the block leaves one clock with every buffer off, so the two byte groups are never driven in the same clock.

Top module: `sar_host_if`

## Requirements
- R1: A conversion starts on the clock edge at which `chip_en`=1, `chip_sel_n`=0 and `rd_convn`=0 first hold together, whichever of them arrived last, including all three at once; `busy` is 1 after that edge and `dac_code` is then 0x800.
- R2: Holding the convert condition after a conversion has finished does not start another one; a new start needs the condition to go false and then true again.
- R3: `busy` stays high for exactly 12 clocks per conversion and is low otherwise.
- R4: A convert condition that rises while `busy` is high is ignored: the running search continues unchanged and the condition, if still held when `busy` falls, does not start a conversion.
- R5: While `busy` is high, `dout_oe` is all zero and `dout` is zero.
- R6: `dout_oe` is non-zero only in the clock after one in which `rd_convn`=1, `busy`=0, `chip_en`=1 and `chip_sel_n`=0 all held; a line whose enable is 0 drives 0.
- R7: With `wide_mode`=1 during a read, `dout_oe`=0xFFF and `dout` equals the result, whatever `byte_sel` does.
- R8: With `wide_mode`=0 and `byte_sel`=0 held, `dout_oe`=0xFF0 and `dout` is result[11:4] on bits 11..4 with bits 3..0 zero.
- R9: With `wide_mode`=0 and `byte_sel`=1 held, `dout_oe`=0x0FF, bits 7..4 of `dout` are driven 0 and bits 3..0 carry result[3:0].
- R10: With `wide_mode`=0, a clock in which `byte_sel` differs from its value in the previous clock gives all enables off in the next clock, so 0xFF0 and 0x0FF never follow each other directly.
- R11: Each decision clock keeps the current trial bit if `cmp_in`=1 and clears it if not, then sets the next lower bit, MSB first; after the LSB decision the result holds the final word, so a comparator that reports input >= `dac_code` yields that input value.
- R12: After synchronous reset `busy`, `dac_code`, `dout` and `dout_oe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Enable, active high |
| chip_sel_n | input | 1 | Select, active low |
| rd_convn | input | 1 | 1 = read, 0 = convert |
| byte_sel | input | 1 | Byte choice on an 8-bit bus: 0 high byte, 1 low byte |
| wide_mode | input | 1 | 1 = full-width read, 0 = two-byte read |
| cmp_in | input | 1 | Comparator: 1 when the analog input >= trial word |
| busy | output | 1 | Conversion in progress |
| dac_code | output | 12 | Current trial word for the internal DAC |
| dout | output | 12 | Registered data lines |
| dout_oe | output | 12 | Per-line output enables |

## Verification
The hardest case to reach is a convert condition that rises during a running search and is still held when `busy` drops. Here the block must neither restart nor start again afterwards. The stimulus reaches it by pulsing `rd_convn` high and back low in the middle of a conversion and then holding it low well past the end. A further hard case is `byte_sel` changing on every clock in byte mode, which must keep every buffer off for the whole stretch. Both cases are compared clock by clock against a behavioural model that holds its own analog input value.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

  typedef enum logic [2:0] {
    RD_IDLE,
    RD_WIDE,
    RD_HIGH,
    RD_LOW,
    RD_GAP
  } rd_mode_e;

endpackage

// File: rtl/sar_start_gate.sv
module sar_start_gate (
  input  logic clk,
  input  logic rst,
  input  logic chip_en,
  input  logic chip_sel_n,
  input  logic rd_convn,
  input  logic busy,
  output logic start
);

  logic cond;
  logic cond_q;

  assign cond  = chip_en & ~chip_sel_n & ~rd_convn;
  assign start = cond & ~cond_q & ~busy;

  always_ff @(posedge clk) begin
    if (rst) cond_q <= 1'b0;
    else     cond_q <= cond;
  end

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_in,
  output logic             busy,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result
);

  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] probe;
  logic [RES_W-1:0] decided;

  assign decided = cmp_in ? trial : (trial & ~probe);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      trial  <= '0;
      probe  <= '0;
      result <= '0;
    end else if (busy) begin
      if (probe[0]) begin
        busy   <= 1'b0;
        trial  <= decided;
        result <= decided;
        probe  <= '0;
      end else begin
        trial <= decided | (probe >> 1);
        probe <= probe >> 1;
      end
    end else if (start) begin
      busy  <= 1'b1;
      trial <= MSB_ONLY;
      probe <= MSB_ONLY;
    end
  end

endmodule

// File: rtl/sar_out_steer.sv
module sar_out_steer
  import sar_host_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chip_en,
  input  logic             chip_sel_n,
  input  logic             rd_convn,
  input  logic             byte_sel,
  input  logic             wide_mode,
  input  logic             busy,
  input  logic [RES_W-1:0] result,
  output logic [RES_W-1:0] dout,
  output logic [RES_W-1:0] dout_oe
);

  localparam int               LO_W    = RES_W - BYTE_W;
  localparam logic [RES_W-1:0] ALL     = '1;
  localparam logic [RES_W-1:0] HI_MASK = ALL << LO_W;
  localparam logic [RES_W-1:0] LO_OE   = ALL >> (RES_W - BYTE_W);
  localparam logic [RES_W-1:0] LO_DATA = ALL >> BYTE_W;

  rd_mode_e         mode;
  logic             read_ok;
  logic             sel_q;
  logic [RES_W-1:0] oe_nx;
  logic [RES_W-1:0] dat_nx;

  assign read_ok = rd_convn & chip_en & ~chip_sel_n & ~busy;

  always_comb begin
    if (!read_ok)              mode = RD_IDLE;
    else if (wide_mode)        mode = RD_WIDE;
    else if (byte_sel != sel_q) mode = RD_GAP;
    else if (byte_sel)         mode = RD_LOW;
    else                       mode = RD_HIGH;
  end

  always_comb begin
    oe_nx  = '0;
    dat_nx = '0;
    case (mode)
      RD_WIDE: begin
        oe_nx  = ALL;
        dat_nx = result;
      end
      RD_HIGH: begin
        oe_nx  = HI_MASK;
        dat_nx = result & HI_MASK;
      end
      RD_LOW: begin
        oe_nx  = LO_OE;
        dat_nx = result & LO_DATA;
      end
      default: begin
        oe_nx  = '0;
        dat_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      dout    <= '0;
      dout_oe <= '0;
    end else begin
      sel_q   <= byte_sel;
      dout    <= dat_nx;
      dout_oe <= oe_nx;
    end
  end

endmodule

// File: rtl/sar_host_if.sv
module sar_host_if #(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chip_en,
  input  logic             chip_sel_n,
  input  logic             rd_convn,
  input  logic             byte_sel,
  input  logic             wide_mode,
  input  logic             cmp_in,
  output logic             busy,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] dout,
  output logic [RES_W-1:0] dout_oe
);

  logic             start;
  logic [RES_W-1:0] result;

  sar_start_gate u_start (
    .clk        (clk),
    .rst        (rst),
    .chip_en    (chip_en),
    .chip_sel_n (chip_sel_n),
    .rd_convn   (rd_convn),
    .busy       (busy),
    .start      (start)
  );

  sar_seq #(.RES_W(RES_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .cmp_in (cmp_in),
    .busy   (busy),
    .trial  (dac_code),
    .result (result)
  );

  sar_out_steer #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_steer (
    .clk        (clk),
    .rst        (rst),
    .chip_en    (chip_en),
    .chip_sel_n (chip_sel_n),
    .rd_convn   (rd_convn),
    .byte_sel   (byte_sel),
    .wide_mode  (wide_mode),
    .busy       (busy),
    .result     (result),
    .dout       (dout),
    .dout_oe    (dout_oe)
  );

endmodule

// File: rtl/sar_host_chk.sv
module sar_host_chk #(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             chip_en,
  input logic             chip_sel_n,
  input logic             rd_convn,
  input logic             busy,
  input logic [RES_W-1:0] dac_code,
  input logic [RES_W-1:0] dout_oe
);

  localparam int               LEN_W    = $clog2(RES_W + 2);
  localparam logic [RES_W-1:0] ALL      = '1;
  localparam logic [RES_W-1:0] HI_MASK  = ALL << (RES_W - BYTE_W);
  localparam logic [RES_W-1:0] LO_OE    = ALL >> (RES_W - BYTE_W);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst)       len_q <= '0;
    else if (busy) len_q <= len_q + 1'b1;
    else           len_q <= '0;
  end

  assert_start_cond_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(chip_en && !chip_sel_n && !rd_convn));

  assert_start_msb_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> dac_code == MSB_ONLY);

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> len_q == LEN_W'(RES_W));

  assert_hiz_busy_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> dout_oe == '0);

  assert_read_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (dout_oe != '0) |-> $past(rd_convn && chip_en && !chip_sel_n && !busy));

  assert_bbm_lo_R10: assert property (@(posedge clk) disable iff (rst)
    (dout_oe == LO_OE) |-> $past(dout_oe) != HI_MASK);

  assert_bbm_hi_R10: assert property (@(posedge clk) disable iff (rst)
    (dout_oe == HI_MASK) |-> $past(dout_oe) != LO_OE);

endmodule

bind sar_host_if sar_host_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chip_en    (chip_en),
  .chip_sel_n (chip_sel_n),
  .rd_convn   (rd_convn),
  .busy       (busy),
  .dac_code   (dac_code),
  .dout_oe    (dout_oe)
);

// File: tb/sar_host_if_test.sv
module sar_host_if_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_en = 1'b0, chip_sel_n = 1'b1, rd_convn = 1'b1;
  logic byte_sel = 1'b0, wide_mode = 1'b1;
  logic cmp_in;
  logic busy;
  logic [W-1:0] dac_code, dout, dout_oe;

  int vin = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  int m_busy, m_bit, m_trial, m_result, m_prev_cond, m_prev_ao;
  int e_oe, e_dout;
  string e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp_in = (vin >= int'(dac_code));

  sar_host_if uut (
    .clk(clk), .rst(rst), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
    .rd_convn(rd_convn), .byte_sel(byte_sel), .wide_mode(wide_mode),
    .cmp_in(cmp_in), .busy(busy), .dac_code(dac_code), .dout(dout),
    .dout_oe(dout_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int cond, rd_ok, nt;
    if (rst) begin
      m_busy = 0; m_bit = 0; m_trial = 0; m_result = 0;
      m_prev_cond = 0; m_prev_ao = 0; e_oe = 0; e_dout = 0; e_tag = "R12";
    end else begin
      cond  = (chip_en && !chip_sel_n && !rd_convn) ? 1 : 0;
      rd_ok = (rd_convn && m_busy == 0 && chip_en && !chip_sel_n) ? 1 : 0;
      if (!rd_ok) begin
        e_oe = 0; e_dout = 0; e_tag = (m_busy != 0) ? "R5" : "R6";
      end else if (wide_mode) begin
        e_oe = 'hFFF; e_dout = m_result; e_tag = "R7";
      end else if (int'(byte_sel) != m_prev_ao) begin
        e_oe = 0; e_dout = 0; e_tag = "R10";
      end else if (!byte_sel) begin
        e_oe = 'hFF0; e_dout = m_result & 'hFF0; e_tag = "R8";
      end else begin
        e_oe = 'h0FF; e_dout = m_result & 'h00F; e_tag = "R9";
      end
      m_prev_ao = int'(byte_sel);
      if (m_busy != 0) begin
        nt = (vin >= m_trial) ? m_trial : (m_trial & ~(1 << m_bit));
        if (m_bit == 0) begin
          m_result = nt; m_trial = nt; m_busy = 0;
        end else begin
          m_bit--; m_trial = nt | (1 << m_bit);
        end
      end else if (cond != 0 && m_prev_cond == 0) begin
        m_busy = 1; m_bit = W-1; m_trial = 1 << (W-1);
      end
      m_prev_cond = cond;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(busy) == m_busy, "R3", int'(busy), m_busy);
      chk(int'(dac_code) == m_trial, "R11", int'(dac_code), m_trial);
      chk(int'(dout_oe) == e_oe, e_tag, int'(dout_oe), e_oe);
      chk(int'(dout) == e_dout, e_tag, int'(dout), e_dout);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic convert_and_wait(input int v);
    vin = v;
    chip_en = 1'b1; chip_sel_n = 1'b0; rd_convn = 1'b0;
    step(1);
    chk(busy == 1'b1, "R1", int'(busy), 1);
    step(12);
    chk(busy == 1'b0, "R3", int'(busy), 0);
    rd_convn = 1'b1;
    step(1);
  endtask

  initial begin
    step(3);
    chk(busy == 1'b0 && dout_oe == '0 && dout == '0 && dac_code == '0, "R12",
        int'(dout_oe), 0);
    rst = 1'b0;
    step(2);
    chk(dout_oe == '0, "R12", int'(dout_oe), 0);

    // R1: enable arrives last
    vin = 'hA5C;
    rd_convn = 1'b0; chip_sel_n = 1'b0;
    step(2);
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chip_en = 1'b1;
    step(1);
    chk(busy == 1'b1 && dac_code == 12'h800, "R1", int'(dac_code), 'h800);
    step(12);
    // R2: condition still held, must not restart
    step(5);
    chk(busy == 1'b0, "R2", int'(busy), 0);
    rd_convn = 1'b1;
    step(2);
    chk(dout == 12'hA5C && dout_oe == 12'hFFF, "R11", int'(dout), 'hA5C);
    // R7: byte_sel toggling has no effect in wide mode
    for (int i = 0; i < 4; i++) begin
      byte_sel = ~byte_sel;
      step(1);
      chk(dout_oe == 12'hFFF, "R7", int'(dout_oe), 'hFFF);
    end

    // R1: all three change together
    chip_en = 1'b0; chip_sel_n = 1'b1;
    step(2);
    chk(dout_oe == '0, "R6", int'(dout_oe), 0);
    vin = 'h3C1;
    chip_en = 1'b1; chip_sel_n = 1'b0; rd_convn = 1'b0;
    step(1);
    chk(busy == 1'b1, "R1", int'(busy), 1);
    // R4: a new rising condition while busy
    step(4);
    rd_convn = 1'b1;
    step(1);
    chk(dout_oe == '0, "R5", int'(dout_oe), 0);
    rd_convn = 1'b0;
    step(7);
    chk(busy == 1'b0, "R4", int'(busy), 0);
    step(6);
    chk(busy == 1'b0, "R4", int'(busy), 0);

    // byte mode reads
    wide_mode = 1'b0; byte_sel = 1'b0; rd_convn = 1'b1;
    step(3);
    chk(dout_oe == 12'hFF0 && dout == 12'h3C0, "R8", int'(dout), 'h3C0);
    byte_sel = 1'b1;
    step(1);
    chk(dout_oe == '0, "R10", int'(dout_oe), 0);
    step(1);
    chk(dout_oe == 12'h0FF && dout == 12'h001, "R9", int'(dout), 'h001);
    for (int i = 0; i < 6; i++) begin
      byte_sel = ~byte_sel;
      step(1);
      chk(dout_oe == '0, "R10", int'(dout_oe), 0);
    end

    // extremes and read gating
    wide_mode = 1'b1;
    convert_and_wait(4095);
    step(1);
    chk(dout == 12'hFFF, "R11", int'(dout), 'hFFF);
    convert_and_wait(0);
    step(1);
    chk(dout == 12'h000 && dout_oe == 12'hFFF, "R11", int'(dout), 0);
    chip_sel_n = 1'b1;
    step(2);
    chk(dout_oe == '0, "R6", int'(dout_oe), 0);
    for (int k = 0; k < 20; k++) begin
      wide_mode = k[0];
      byte_sel = k[1];
      chip_sel_n = 1'b0;
      convert_and_wait((k * 733 + 91) % 4096);
      step(3);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule